// File: doc/BRIEF.md
# Byte-Stream Cipher Engine with Saveable State

This block is an ARC-4 style stream cipher that a host drives through a small register map. The host writes a key, a key length and a command; the engine then builds its 256-entry substitution table, one exchange per clock. After that, every 64-bit word written into the data window is combined with the keystream and can be read back from the same window. The byte order is most significant first.

The full cipher state can be moved out and back in through those same data FIFOs. That state is the table plus the two running indices and the prefetched table entry. One packet flow can therefore be parked while another uses the engine, and later resumed exactly where it stopped, without running the key schedule again. Host mistakes are recorded as sticky flags that drive one interrupt line. These mistakes are: reading an empty output FIFO, writing a full input FIFO, reading a key register, and touching the pointer register while the engine works.

Top module: `scx_stream_cipher`

## Requirements
- R1: After reset, the status register (address 1), the pointer register (address 5), host_rdata and irq all read zero, and the engine is not keyed.
- R2: Writing op 1 to CTRL (address 0, bits 1:0) does the following:
  - It fills the table with the identity and then performs 256 exchanges. The running index is j = j + S[i] + key byte.
  - Key bytes are taken from the top byte of KEY_A (address 3) downwards, then from KEY_B (address 4). KEYLEN (address 2, bits 3:0) + 1 bytes are used, repeated cyclically.
  - Afterwards the pointer register reads {I, J, S[I+1]} in bits 23:16, 15:8 and 7:0, with I = J = 0.
- R3: When keyed and idle, each input word is turned into an output word. Each byte is XORed with S[(S[I]+S[J]) mod 256] after the usual index step and exchange, most significant byte first. The keystream continues across words.
- R4: A write anywhere in addresses 8 to 15 pushes one word into the input FIFO. A read there pops one word from the output FIFO. A push into a full FIFO is dropped and sets status bit 1. A pop from an empty FIFO returns zero and sets status bit 2.
- R5: A read of address 3 or 4 returns zero and sets status bit 4.
- R6: A write to the pointer register while busy is discarded and sets status bit 3. When idle, the write replaces I, J and the prefetched byte.
- R7: Op 3 emits 33 words holding S[0..255], then I, J and S[I+1], eight bytes per word with the most significant byte first. The last word is zero padded. The cipher state is left unchanged.
- R8: Op 2 consumes 33 words in that same layout and restores the state. The keystream that follows is identical to the keystream of the state that was saved.
- R9: Status bits 1 to 4 are sticky and are cleared by writing 1 to them. irq is high whenever any of them is set.
- R10: Status bit 0 (busy) is set during any command or word in progress. During a key schedule, neither FIFO is touched by the engine, and commands written while busy are ignored. Status bit 5 shows keyed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe; data appears on host_rdata after the next edge |
| host_addr | input | 4 | Word address |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Registered read data |
| irq | output | 1 | OR of the sticky error flags |

## Verification
The hardest situation to reach is resuming a parked flow. The saved state has to be captured and the engine moved on so that its live state differs. The 33 words then have to be fed back, and the keystream must be shown to pick up exactly at the saved point. The stimulus first keys the engine and runs random words through it. It then unloads the state while the host is also poking the pointer register, and processes more random words. Finally it reloads the captured words and compares fresh ciphertext against a bench model restored to the saved state. A full input FIFO is reached by writing words during a key schedule, when the engine is not allowed to drain them.

// File: rtl/scx_pkg.sv
package scx_pkg;
  localparam int SBOX_N    = 256;
  localparam int CTX_BYTES = SBOX_N + 3;
  localparam int CTX_WORDS = (CTX_BYTES + 7) / 8;

  typedef enum logic [2:0] {
    E_IDLE, E_INIT, E_KSA, E_PREF, E_PROC, E_LOAD, E_UNLD
  } eng_st_e;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0, OP_REKEY = 2'd1, OP_LOAD = 2'd2, OP_UNLOAD = 2'd3
  } op_e;

  typedef struct packed {
    logic addr_err;
    logic ctx_err;
    logic out_unf;
    logic in_ovf;
  } err_t;

  // value found at idx once entries ai and nj have been exchanged
  function automatic logic [7:0] swap_view(logic [7:0] idx, logic [7:0] ai,
                                           logic [7:0] nj, logic [7:0] a,
                                           logic [7:0] b, logic [7:0] raw);
    if (idx == nj)      return a;
    else if (idx == ai) return b;
    else                return raw;
  endfunction

  function automatic logic [7:0] ksa_next_j(logic [7:0] j, logic [7:0] si,
                                            logic [7:0] kb);
    return j + si + kb;
  endfunction
endpackage

// File: rtl/scx_fifo.sv
module scx_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   count;
  logic do_push, do_pop;

  assign full    = (count == (AW+1)'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  function automatic logic [AW-1:0] wrap_inc(logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (do_push) wp <= wrap_inc(wp);
      if (do_pop)  rp <= wrap_inc(rp);
      count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  // R4: a push into a full FIFO is dropped
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (full && $stable(wp)));
  // R4: a pop from an empty FIFO leaves it empty
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (empty && $stable(rp)));
endmodule

// File: rtl/scx_engine.sv
module scx_engine
  import scx_pkg::*;
#(
  parameter int KEY_BYTES = 16,
  localparam int KW  = KEY_BYTES * 8,
  localparam int KPW = $clog2(KEY_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_vld,
  input  op_e           cmd_op,
  input  logic [KW-1:0] key_bits,
  input  logic [KPW-1:0] key_last,
  input  logic          ptr_wr,
  input  logic [23:0]   ptr_wdata,
  input  logic          in_empty,
  input  logic [63:0]   in_data,
  output logic          in_pop,
  input  logic          out_full,
  output logic          out_push,
  output logic [63:0]   out_data,
  output logic          busy,
  output logic          keyed,
  output logic [23:0]   ptr_rd
);
  eng_st_e state;
  logic [7:0] sbox [SBOX_N];
  logic [7:0] ptr_i, ptr_j, ptr_n;
  logic [7:0] cnt;
  logic [KPW-1:0] kp;
  logic [63:0] dat;

  // keystream step
  logic [7:0] ai, ai1, a, nj, b, ksum, kbyte, nn;
  // key schedule step
  logic [7:0] si, sj, kjn, kb;
  // context word positions
  logic [8:0] pos [8];
  logic [63:0] unld_word;
  logic data_go, cnt_last_ctx;

  assign busy   = (state != E_IDLE);
  assign ptr_rd = {ptr_i, ptr_j, ptr_n};

  always_comb begin
    ai    = ptr_i + 8'd1;
    ai1   = ai + 8'd1;
    a     = ptr_n;
    nj    = ptr_j + a;
    b     = sbox[nj];
    ksum  = a + b;
    kbyte = swap_view(ksum, ai, nj, a, b, sbox[ksum]);
    nn    = swap_view(ai1, ai, nj, a, b, sbox[ai1]);
  end

  always_comb begin
    kb  = key_bits[(KEY_BYTES - 1 - int'(kp)) * 8 +: 8];
    si  = sbox[cnt];
    kjn = ksa_next_j(ptr_j, si, kb);
    sj  = sbox[kjn];
  end

  for (genvar k = 0; k < 8; k++) begin : g_ctx
    assign pos[k] = {cnt[5:0], 3'(k)};
    always_comb begin
      if (!pos[k][8])                unld_word[63-8*k -: 8] = sbox[pos[k][7:0]];
      else if (pos[k] == 9'd256)     unld_word[63-8*k -: 8] = ptr_i;
      else if (pos[k] == 9'd257)     unld_word[63-8*k -: 8] = ptr_j;
      else if (pos[k] == 9'd258)     unld_word[63-8*k -: 8] = ptr_n;
      else                           unld_word[63-8*k -: 8] = 8'h00;
    end
  end

  assign cnt_last_ctx = (cnt == 8'(CTX_WORDS - 1));
  assign data_go  = (state == E_IDLE) && !cmd_vld && !ptr_wr && keyed &&
                    !in_empty && !out_full;
  assign in_pop   = data_go || ((state == E_LOAD) && !in_empty);
  assign out_push = ((state == E_PROC) && (cnt == 8'd7)) ||
                    ((state == E_UNLD) && !out_full);
  assign out_data = (state == E_PROC) ? {dat[55:0], dat[63:56] ^ kbyte} : unld_word;

  // table storage
  always_ff @(posedge clk) begin
    unique case (state)
      E_INIT: for (int i = 0; i < SBOX_N; i++) sbox[i] <= 8'(i);
      E_KSA: begin
        sbox[cnt] <= sj;
        sbox[kjn] <= si;
      end
      E_PROC: begin
        sbox[ai] <= b;
        sbox[nj] <= a;
      end
      E_LOAD: if (!in_empty) begin
        for (int k = 0; k < 8; k++)
          if (!pos[k][8]) sbox[pos[k][7:0]] <= in_data[63-8*k -: 8];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= E_IDLE; cnt <= '0; kp <= '0; dat <= '0; keyed <= 1'b0;
      ptr_i <= '0; ptr_j <= '0; ptr_n <= '0;
    end else begin
      unique case (state)
        E_IDLE: begin
          if (cmd_vld) begin
            cnt <= '0;
            kp  <= '0;
            unique case (cmd_op)
              OP_REKEY:  state <= E_INIT;
              OP_LOAD:   state <= E_LOAD;
              OP_UNLOAD: state <= E_UNLD;
              default:   ;
            endcase
          end else if (ptr_wr) begin
            {ptr_i, ptr_j, ptr_n} <= ptr_wdata;
          end else if (data_go) begin
            dat   <= in_data;
            cnt   <= '0;
            state <= E_PROC;
          end
        end
        E_INIT: begin
          ptr_j <= '0;
          keyed <= 1'b0;
          state <= E_KSA;
        end
        E_KSA: begin
          ptr_j <= kjn;
          kp    <= (kp == key_last) ? '0 : kp + 1'b1;
          cnt   <= cnt + 8'd1;
          if (cnt == 8'd255) state <= E_PREF;
        end
        E_PREF: begin
          ptr_i <= '0;
          ptr_j <= '0;
          ptr_n <= sbox[1];
          keyed <= 1'b1;
          state <= E_IDLE;
        end
        E_PROC: begin
          ptr_i <= ai;
          ptr_j <= nj;
          ptr_n <= nn;
          dat   <= {dat[55:0], dat[63:56] ^ kbyte};
          cnt   <= cnt + 8'd1;
          if (cnt == 8'd7) state <= E_IDLE;
        end
        E_LOAD: if (!in_empty) begin
          for (int k = 0; k < 8; k++) begin
            if (pos[k] == 9'd256) ptr_i <= in_data[63-8*k -: 8];
            if (pos[k] == 9'd257) ptr_j <= in_data[63-8*k -: 8];
            if (pos[k] == 9'd258) ptr_n <= in_data[63-8*k -: 8];
          end
          cnt <= cnt + 8'd1;
          if (cnt_last_ctx) begin
            state <= E_IDLE;
            keyed <= 1'b1;
          end
        end
        E_UNLD: if (!out_full) begin
          cnt <= cnt + 8'd1;
          if (cnt_last_ctx) state <= E_IDLE;
        end
        default: state <= E_IDLE;
      endcase
    end
  end

  // R10: no FIFO traffic while the table is being built
  p_ksa_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state inside {E_INIT, E_KSA, E_PREF}) |-> (!in_pop && !out_push));
  // R4: engine never pushes into a full output FIFO or pops an empty input FIFO
  p_push_room_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_push |-> !out_full);
  p_pop_avail_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_pop |-> !in_empty);
  // R2: the schedule ends with the prefetch step and pointers at zero
  p_ksa_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == E_PREF) |=> (keyed && ptr_i == 8'd0 && ptr_j == 8'd0 && !busy));
  // R8: the last context word leaves the engine keyed and idle
  p_load_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == E_LOAD && in_pop && cnt_last_ctx) |=> (keyed && !busy));
  // R7: unloading never disturbs the pointers
  p_unld_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == E_UNLD) |=> $stable(ptr_rd));
endmodule

// File: rtl/scx_stream_cipher.sv
module scx_stream_cipher
  import scx_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int ADDR_W     = 4,
  parameter int KEY_BYTES  = 16,
  localparam int KW  = KEY_BYTES * 8,
  localparam int KPW = $clog2(KEY_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [63:0]       host_wdata,
  output logic [63:0]       host_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_KLEN = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_KEYA = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_KEYB = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_PTR  = ADDR_W'(5);

  logic [KW/2-1:0] key_a, key_b;
  logic [KPW-1:0]  key_len_m1;
  err_t flags, err_set, err_clr;

  logic win;
  logic in_push, in_pop, in_full, in_empty;
  logic out_push, out_pop, out_full, out_empty;
  logic [63:0] in_dout, out_din, out_dout;
  logic eng_busy, eng_keyed, cmd_vld, ptr_wr;
  logic [23:0] ptr_rd;
  logic key_rd, ptr_guard;

  assign win       = host_addr[ADDR_W-1];
  assign in_push   = host_wr && win;
  assign out_pop   = host_rd && win;
  assign cmd_vld   = host_wr && !win && host_addr == A_CTRL &&
                     host_wdata[1:0] != 2'b00 && !eng_busy;
  assign ptr_guard = host_wr && !win && host_addr == A_PTR && eng_busy;
  assign ptr_wr    = host_wr && !win && host_addr == A_PTR && !eng_busy;
  assign key_rd    = host_rd && !win && (host_addr == A_KEYA || host_addr == A_KEYB);

  always_comb begin
    err_set.in_ovf   = in_push && in_full;
    err_set.out_unf  = out_pop && out_empty;
    err_set.ctx_err  = ptr_guard;
    err_set.addr_err = key_rd;
    err_clr = (host_wr && !win && host_addr == A_STAT) ? err_t'(host_wdata[4:1]) : '0;
  end

  assign irq = |flags;

  scx_fifo #(.W(64), .DEPTH(FIFO_DEPTH)) u_in_fifo (
    .clk, .rst_n, .push(in_push), .din(host_wdata), .pop(in_pop),
    .dout(in_dout), .full(in_full), .empty(in_empty));

  scx_fifo #(.W(64), .DEPTH(FIFO_DEPTH)) u_out_fifo (
    .clk, .rst_n, .push(out_push), .din(out_din), .pop(out_pop),
    .dout(out_dout), .full(out_full), .empty(out_empty));

  scx_engine #(.KEY_BYTES(KEY_BYTES)) u_engine (
    .clk, .rst_n, .cmd_vld, .cmd_op(op_e'(host_wdata[1:0])),
    .key_bits({key_a, key_b}), .key_last(key_len_m1),
    .ptr_wr, .ptr_wdata(host_wdata[23:0]),
    .in_empty, .in_data(in_dout), .in_pop,
    .out_full, .out_push, .out_data(out_din),
    .busy(eng_busy), .keyed(eng_keyed), .ptr_rd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_a <= '0; key_b <= '0; key_len_m1 <= '0; flags <= '0;
    end else begin
      flags <= (flags & ~err_clr) | err_set;
      if (host_wr && !win) begin
        if (host_addr == A_KEYA) key_a <= host_wdata[KW/2-1:0];
        if (host_addr == A_KEYB) key_b <= host_wdata[KW/2-1:0];
        if (host_addr == A_KLEN) key_len_m1 <= host_wdata[KPW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rdata <= '0;
    end else if (host_rd) begin
      if (win)                      host_rdata <= out_empty ? '0 : out_dout;
      else if (host_addr == A_STAT) host_rdata <= 64'({eng_keyed, flags, eng_busy});
      else if (host_addr == A_KLEN) host_rdata <= 64'(key_len_m1);
      else if (host_addr == A_PTR)  host_rdata <= 64'(ptr_rd);
      else                          host_rdata <= '0;
    end
  end

  // R5: a key read is flagged on the next cycle
  p_key_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    key_rd |=> (flags.addr_err && host_rdata == 64'd0));
  // R6: a pointer write during work is flagged
  p_ptr_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_guard |=> flags.ctx_err);
  // R9: flags stay set unless cleared
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flags.in_ovf && !(host_wr && !win && host_addr == A_STAT)) |=> flags.in_ovf);
  // R4: an empty pop reads back as zero
  p_unf_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_pop && out_empty) |=> (host_rdata == 64'd0 && flags.out_unf));
endmodule

// File: tb/scx_stream_cipher_tb.sv
module scx_stream_cipher_tb;
  localparam int DEPTH = 8;
  localparam logic [3:0] A_CTRL = 4'd0, A_STAT = 4'd1, A_KLEN = 4'd2,
                         A_KEYA = 4'd3, A_KEYB = 4'd4, A_PTR = 4'd5, A_WIN = 4'd8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [3:0] host_addr = '0;
  logic [63:0] host_wdata = '0;
  logic [63:0] host_rdata;
  logic irq;

  always #2.5 clk = ~clk;

  scx_stream_cipher #(.FIFO_DEPTH(DEPTH)) u_dut (
    .clk, .rst_n, .host_wr, .host_rd, .host_addr, .host_wdata, .host_rdata, .irq);

  int errors = 0;
  int checks = 0;

  logic [7:0] ms [256];
  logic [7:0] mi, mj;
  logic [63:0] saved_w [33];
  logic [7:0] saved_s [256];
  logic [7:0] saved_i, saved_j;
  logic [127:0] cur_key;
  int cur_len;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hw(input logic [3:0] a, input logic [63:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hr(input logic [3:0] a, output logic [63:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic wait_idle();
    logic [63:0] st;
    for (int n = 0; n < 4000; n++) begin
      hr(A_STAT, st);
      if (!st[0]) break;
    end
  endtask

  // bench model of the cipher
  task automatic m_ksa(input logic [127:0] key, input int len);
    logic [7:0] t, kbv;
    for (int i = 0; i < 256; i++) ms[i] = 8'(i);
    mj = 0;
    for (int i = 0; i < 256; i++) begin
      kbv = key[127 - 8*(i % len) -: 8];
      mj = mj + ms[i] + kbv;
      t = ms[i]; ms[i] = ms[mj]; ms[mj] = t;
    end
    mi = 0; mj = 0;
  endtask

  task automatic m_word(input logic [63:0] pin, output logic [63:0] pout);
    logic [7:0] t, ks;
    for (int k = 0; k < 8; k++) begin
      mi = mi + 8'd1;
      mj = mj + ms[mi];
      t = ms[mi]; ms[mi] = ms[mj]; ms[mj] = t;
      ks = ms[8'(ms[mi] + ms[mj])];
      pout[63-8*k -: 8] = pin[63-8*k -: 8] ^ ks;
    end
  endtask

  function automatic logic [63:0] m_ctx_word(input int w);
    logic [63:0] r;
    int bi;
    for (int k = 0; k < 8; k++) begin
      bi = w*8 + k;
      if (bi < 256)       r[63-8*k -: 8] = ms[bi];
      else if (bi == 256) r[63-8*k -: 8] = mi;
      else if (bi == 257) r[63-8*k -: 8] = mj;
      else if (bi == 258) r[63-8*k -: 8] = ms[8'(mi + 8'd1)];
      else                r[63-8*k -: 8] = 8'h00;
    end
    return r;
  endfunction

  task automatic run_batch(input string tag);
    int nw;
    logic [63:0] pin [8];
    logic [63:0] exp [8];
    logic [63:0] got;
    nw = $urandom_range(1, 6);
    for (int i = 0; i < nw; i++) begin
      pin[i] = {$urandom, $urandom};
      if (i == 0) pin[i] = 64'h0;
      m_word(pin[i], exp[i]);
      hw(A_WIN | 4'(i), pin[i]);
    end
    repeat (12*nw + 10) @(negedge clk);
    for (int i = 0; i < nw; i++) begin
      hr(4'hF - 4'(i), got);
      check(tag, got, exp[i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] d;
    logic [3:0] ksz;
    void'($urandom(32'd20250611));
    repeat (5) @(negedge clk);
    // R1: reset state
    check("R1 rdata", host_rdata, 64'd0);
    check("R1 irq", 64'(irq), 64'd0);
    rst_n = 1'b1;
    hr(A_STAT, d); check("R1 status", d, 64'd0);
    hr(A_PTR, d);  check("R1 ptr", d, 64'd0);

    // R4: empty pop returns zero and flags underflow; R9 sticky and W1C
    hr(A_WIN, d); check("R4 empty pop data", d, 64'd0);
    hr(A_STAT, d); check("R4 underflow flag", d, 64'h4);
    check("R9 irq on flag", 64'(irq), 64'd1);
    hw(A_STAT, 64'h2);
    hr(A_STAT, d); check("R9 clear other bit keeps flag", d, 64'h4);
    hw(A_STAT, 64'h4);
    hr(A_STAT, d); check("R9 w1c", d, 64'h0);
    check("R9 irq low", 64'(irq), 64'd0);

    // R5: key reads
    hw(A_KEYA, 64'hFFFF_FFFF_FFFF_FFFF);
    hr(A_KEYA, d); check("R5 key read data", d, 64'd0);
    hr(A_STAT, d); check("R5 addr err", d, 64'h10);
    hw(A_STAT, 64'h1E);

    // R2/R3: several keys and key lengths
    for (int r = 0; r < 3; r++) begin
      ksz = (r == 0) ? 4'd15 : (r == 1) ? 4'd0 : 4'($urandom_range(1, 14));
      cur_key = {$urandom, $urandom, $urandom, $urandom};
      cur_len = int'(ksz) + 1;
      hw(A_KLEN, 64'(ksz));
      hw(A_KEYA, cur_key[127:64]);
      hw(A_KEYB, cur_key[63:0]);
      hw(A_CTRL, 64'd1);
      hr(A_STAT, d); check("R10 busy during schedule", 64'(d[0]), 64'd1);
      wait_idle();
      m_ksa(cur_key, cur_len);
      hr(A_STAT, d); check("R10 keyed idle", d, 64'h20);
      hr(A_PTR, d); check("R2 pointers after schedule", d, 64'({8'd0, 8'd0, ms[1]}));
      run_batch("R3 batch a");
      run_batch("R3 batch b");
    end

    // R7: unload, with a guarded pointer write in the middle (R6)
    hw(A_CTRL, 64'd3);
    hw(A_PTR, 64'hABCDEF);
    repeat (4) @(negedge clk);
    for (int w = 0; w < 33; w++) begin
      saved_w[w] = m_ctx_word(w);
      hr(A_WIN, d);
      check("R7 context word", d, saved_w[w]);
    end
    for (int i = 0; i < 256; i++) saved_s[i] = ms[i];
    saved_i = mi; saved_j = mj;
    wait_idle();
    hr(A_STAT, d); check("R6 ctx err flagged", d, 64'h28);
    hr(A_PTR, d); check("R6 ptr untouched", d, 64'({mi, mj, ms[8'(mi + 8'd1)]}));
    hw(A_STAT, 64'h1E);
    run_batch("R7 state kept after unload");

    // R8: reload and continue from the saved point
    hw(A_CTRL, 64'd2);
    for (int w = 0; w < 33; w++) hw(A_WIN | 4'(w), saved_w[w]);
    wait_idle();
    for (int i = 0; i < 256; i++) ms[i] = saved_s[i];
    mi = saved_i; mj = saved_j;
    hr(A_PTR, d); check("R8 ptr restored", d, 64'({mi, mj, ms[8'(mi + 8'd1)]}));
    run_batch("R8 stream resumed");
    run_batch("R8 stream resumed more");

    // R6: idle pointer write takes effect
    hw(A_PTR, 64'h00_3C5A77);
    hr(A_PTR, d); check("R6 idle ptr write", d, 64'h3C5A77);
    hr(A_STAT, d); check("R6 no flag when idle", d, 64'h20);

    // R4/R10: input overflow while a schedule stalls the FIFO
    hw(A_CTRL, 64'd1);
    for (int i = 0; i < DEPTH + 2; i++) hw(A_WIN, {$urandom, $urandom});
    hr(A_STAT, d); check("R10 busy while filling", 64'(d[0]), 64'd1);
    check("R4 overflow flag", 64'(d[1]), 64'd1);
    hw(A_CTRL, 64'd3);
    hr(A_STAT, d); check("R10 command ignored while busy", 64'(d[2]), 64'd0);
    check("R9 irq set", 64'(irq), 64'd1);
    wait_idle();
    repeat (120) @(negedge clk);
    hw(A_STAT, 64'h1E);
    hr(A_STAT, d); check("R9 all cleared", 64'(d[4:1]), 64'd0);
    check("R9 irq cleared", 64'(irq), 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule